// File: doc/BRIEF.md
# Locked Sequence Link Signalling Controller

This block works in the link clock domain beside an uplink command queue. When a command is written into the queue, the block provides two tag bits for it. The first tag marks the command as part of a locked group because the bus lock was held. The second tag is a one-bit group number that flips each time the lock is released. The bus lock comes from another clock domain. The block passes it through a two-flop synchroniser before using it.

On the dequeue side, the block watches the tags at the queue head and a strobe that says a command is being sent. From these it drives a link-level locked-sequence line. The line rises when the first read of a locked group is sent. It falls once the group is finished. A group is finished when:
- the lock is released and the queue has drained, or
- the head entry carries a different group number, or
- the head entry is not locked.

After the line falls it stays low for at least one cycle. During the end cycle and during that gap, the block raises a hold request. The serialiser keeps the next command back while the hold request is high.

Top module: `lockseq_ctl`

## Requirements
- R1: While reset is asserted, `link_seq`, `hold_off`, `tag_seq` and `tag_seqn` are all 0.
- R2: `tag_seq` equals the value `lock_in` had two rising clock edges earlier (1 = locked).
- R3: `tag_seqn` starts at 0. It inverts at the clock edge that follows the first cycle in which `tag_seq` is 0 after being 1. It holds its value at all other times.
- R4: `link_seq` rises at the clock edge that samples all of the following: `send`=1, `send_read`=1 and `head_seq`=1, with `link_seq` low and no gap cycle pending. The group number of that entry becomes the group's number.
- R5: `link_seq` falls at the clock edge after any cycle in which it is high and one of these holds:
  - `tag_seq`=0 and `q_empty`=1;
  - `q_empty`=0 and `head_seq`=0;
  - `q_empty`=0 and `head_seqn` differs from the group number of the last command sent inside the group.
- R6: After `link_seq` falls, the next cycle is a gap cycle: `link_seq` stays low, and a send strobe sampled in that cycle cannot start a group.
- R7: `hold_off` is 1 exactly in the cycles where the end condition of R5 holds, and in the gap cycle of R6.
- R8: A sent command that is not a read (`send_read`=0), or that is not locked (`head_seq`=0), never raises `link_seq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Bus lock from the bus clock domain, 1 = locked |
| tag_seq | output | 1 | Locked flag for a command being queued now |
| tag_seqn | output | 1 | Group number for a command being queued now |
| head_seq | input | 1 | Locked flag of the queue head entry |
| head_seqn | input | 1 | Group number of the queue head entry |
| q_empty | input | 1 | Queue holds no entries |
| send | input | 1 | Head entry is sent on the link this cycle |
| send_read | input | 1 | The entry being sent is a read |
| link_seq | output | 1 | Locked-sequence line on the link |
| hold_off | output | 1 | Serialiser must not send this cycle |

## Verification
The hardest state to reach is a locked group that ends with the next group's locked read already waiting at the queue head. To get there, the lock must be released and taken again while the first group is still draining. The hold request and the gap then gate that waiting read.

The stimulus starts with a directed sequence that builds exactly this case. It then runs long random stretches in which the lock toggles often while the bench queue fills faster than it drains. These stretches also cover a group ending on an unlocked head and on an empty queue after release.

// File: rtl/lockseq_ctl.sv
module lockseq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_in,
  output logic tag_seq,
  output logic tag_seqn,
  input  logic head_seq,
  input  logic head_seqn,
  input  logic q_empty,
  input  logic send,
  input  logic send_read,
  output logic link_seq,
  output logic hold_off
);

  logic [1:0] sync_q;
  logic       lock_d;
  logic       grp_r;
  logic       active_r;
  logic       gap_r;
  logic       last_r;
  logic       done_now;
  logic       start_now;

  assign tag_seq  = sync_q[1];
  assign tag_seqn = grp_r;

  assign done_now = active_r &&
                    ((!sync_q[1] && q_empty) ||
                     (!q_empty && (!head_seq || (head_seqn != last_r))));

  assign start_now = send && send_read && head_seq && !active_r && !gap_r;

  assign link_seq = active_r;
  assign hold_off = done_now || gap_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      lock_d <= 1'b0;
      grp_r  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], lock_in};
      lock_d <= sync_q[1];
      if (lock_d && !sync_q[1]) grp_r <= !grp_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_r <= 1'b0;
      gap_r    <= 1'b0;
      last_r   <= 1'b0;
    end else begin
      gap_r <= done_now;
      if (done_now)       active_r <= 1'b0;
      else if (start_now) active_r <= 1'b1;
      if (send && (active_r || start_now)) last_r <= head_seqn;
    end
  end

endmodule

module lockseq_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic lock_in,
  input logic tag_seq,
  input logic tag_seqn,
  input logic head_seq,
  input logic send,
  input logic send_read,
  input logic link_seq,
  input logic hold_off
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r2_tag_follows_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (tag_seq == $past(lock_in, 2)));

  a_r3_seqn_flip_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc == 2'd3) && !$stable(tag_seqn)) |-> ($past(tag_seq, 2) && !$past(tag_seq)));

  a_r4_rise_on_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc != 2'd0) && $rose(link_seq)) |-> $past(send && send_read && head_seq));

  a_r6_gap_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc != 2'd0) && $fell(link_seq)) |=> !link_seq);

  a_r7_hold_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc != 2'd0) && $fell(link_seq)) |-> hold_off);

  a_r7_no_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc != 2'd0) && !link_seq && !$past(link_seq)) |-> !hold_off);

endmodule

bind lockseq_ctl lockseq_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .tag_seq(tag_seq),
  .tag_seqn(tag_seqn), .head_seq(head_seq), .send(send),
  .send_read(send_read), .link_seq(link_seq), .hold_off(hold_off)
);

// File: tb/test_lockseq_ctl.sv
module test_lockseq_ctl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_in = 1'b0;
  logic head_seq = 1'b0, head_seqn = 1'b0, q_empty = 1'b1;
  logic send = 1'b0, send_read = 1'b0;
  logic tag_seq, tag_seqn, link_seq, hold_off;

  always #5 clk = ~clk;

  lockseq_ctl i_lockseq_ctl (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .tag_seq(tag_seq),
    .tag_seqn(tag_seqn), .head_seq(head_seq), .head_seqn(head_seqn),
    .q_empty(q_empty), .send(send), .send_read(send_read),
    .link_seq(link_seq), .hold_off(hold_off)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // expected-state registers built from the requirements
  bit m_s1, m_s2, m_s3, m_grp, m_act, m_gap, m_last;
  // bench queue
  bit q_seq [0:15];
  bit q_grp [0:15];
  bit q_rd  [0:15];
  int qn = 0;

  function automatic bit exp_end();
    return m_act && ((!m_s2 && (qn == 0)) ||
                     ((qn != 0) && (!q_seq[0] || (q_grp[0] != m_last))));
  endfunction

  function automatic bit exp_hold();
    return exp_end() || m_gap;
  endfunction

  task automatic check(input bit act, input bit exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit lk, input bit want_push, input bit want_send, input bit rd_new);
    bit p_seq, p_grp, was_act, endc, start;
    lock_in   = lk;
    q_empty   = (qn == 0);
    head_seq  = (qn != 0) ? q_seq[0] : 1'b0;
    head_seqn = (qn != 0) ? q_grp[0] : 1'b0;
    send_read = (qn != 0) ? q_rd[0] : 1'b0;
    send      = want_send && (qn != 0) && !exp_hold();
    #1;
    check(tag_seq,  m_s2,       "R2 tag_seq");
    check(tag_seqn, m_grp,      "R3 tag_seqn");
    check(link_seq, m_act,      "R4,R5,R6,R8 link_seq");
    check(hold_off, exp_hold(), "R7 hold_off");
    p_seq = m_s2;
    p_grp = m_grp;
    @(posedge clk);
    endc    = exp_end();
    was_act = m_act;
    start   = send && send_read && head_seq && !m_act && !m_gap;
    if (m_s3 && !m_s2) m_grp = !m_grp;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = lk;
    m_gap = endc;
    if (endc) m_act = 1'b0;
    else if (start) m_act = 1'b1;
    if (send && (was_act || start)) m_last = head_seqn;
    @(negedge clk);
    if (send) begin
      for (int i = 0; i < 15; i++) begin
        q_seq[i] = q_seq[i+1]; q_grp[i] = q_grp[i+1]; q_rd[i] = q_rd[i+1];
      end
      qn--;
    end
    if (want_push && qn < 16) begin
      q_seq[qn] = p_seq; q_grp[qn] = p_grp; q_rd[qn] = rd_new; qn++;
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_grp = 0; m_act = 0; m_gap = 0; m_last = 0;
    repeat (3) @(negedge clk);
    lock_in = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(link_seq, 1'b0, "R1 link_seq in reset");
    check(hold_off, 1'b0, "R1 hold_off in reset");
    check(tag_seq,  1'b0, "R1 tag_seq in reset");
    check(tag_seqn, 1'b0, "R1 tag_seqn in reset");
    lock_in = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R8: unlocked read and locked write do not start a group
    cycle(0, 1, 0, 1);
    cycle(0, 0, 1, 0);
    check(link_seq, 1'b0, "R8 unlocked read sent");
    cycle(1, 0, 0, 0); cycle(1, 0, 0, 0); cycle(1, 0, 0, 0);
    cycle(1, 1, 0, 0);                 // locked write
    cycle(1, 1, 1, 1);                 // send the write, queue a locked read
    check(link_seq, 1'b0, "R8 locked write sent");
    // group one: two reads, then release and relock with a new-group read waiting
    cycle(1, 1, 1, 1);
    cycle(0, 1, 0, 1);
    cycle(0, 0, 0, 0); cycle(0, 0, 0, 0);
    cycle(1, 0, 0, 0); cycle(1, 0, 0, 0); cycle(1, 1, 0, 1); cycle(1, 1, 0, 1);
    for (int k = 0; k < 12; k++) cycle(1, 0, 1, 0);
    // R5: group ends on an empty queue after release
    for (int k = 0; k < 8; k++) cycle(0, 0, 1, 0);
    check(link_seq, 1'b0, "R5 drained after release");

    // random mix
    begin
      bit lk = 1'b0;
      for (int k = 0; k < 6000; k++) begin
        if ($urandom_range(0, 9) == 0) lk = !lk;
        cycle(lk, ($urandom_range(0, 2) != 0), ($urandom_range(0, 2) != 0),
              ($urandom_range(0, 1) != 0));
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule